// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the word address for each beat of a short burst. A start address is captured on a load cycle. Each later advance cycle steps to the next beat. Only the low-order beat field moves; the upper address bits stay as they were loaded. With the default of two beat bits, a burst has four beats.

Two beat orders can be chosen. The linear order adds the beat number to the start offset and wraps around within the group. The interleaved order XORs the start offset with the beat number. The order is captured together with the start address, so a burst keeps its order until the next load. When the active-low clock enable is deasserted, the sequencer is frozen and the address it presents does not change.

The output comes from registers. The address of a load or advance appears one clock after the enabled edge that captured it.

Top module: `burst_seq`

## Requirements
- R1: While rst_n is low, and after it is released, addr_out is zero and the captured order is linear.
- R2: On an edge with ce_n=0 and advance=0, addr_in is loaded. From the following cycle, addr_out equals addr_in: this is beat 0, the start address.
- R3: On an edge with ce_n=0 and advance=1, addr_out[ADDR_W-1:BEAT_W] keeps its value.
- R4: With linear order (order_ilv=0 at the load), beat k has addr_out[BEAT_W-1:0] = (start + k) mod 2^BEAT_W. For example, a start of 1 gives 1, 2, 3, 0.
- R5: With interleaved order (order_ilv=1 at the load), beat k has addr_out[BEAT_W-1:0] = start XOR k. For example, a start of 1 gives 1, 0, 3, 2, and a start of 2 gives 2, 3, 0, 1.
- R6: Advancing after the last beat of a group returns to the start offset, and the upper bits stay unchanged.
- R7: On an edge with ce_n=1, addr_out does not change, whatever values advance, order_ilv and addr_in have.
- R8: order_ilv is used only on load edges. Changing it during a burst has no effect until the next load.
- R9: A load edge in the middle of a burst starts a new burst at once, from beat 0 of the new address. Loads on consecutive edges each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low clock enable; high freezes the sequencer |
| advance | input | 1 | 1 = step to next beat, 0 = load addr_in |
| order_ilv | input | 1 | Order for the burst being loaded: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Start word address, captured on load edges |
| addr_out | output | ADDR_W | Current word address |

## Verification
On every cycle, the checker verifies these properties:
- A frozen cycle leaves the address unchanged.
- A load presents the input address on the next cycle.
- An advance keeps the upper bits and always changes the beat field.
- A linear step adds one to the beat field.
- An interleaved step toggles the lowest beat bit.

Some behaviours need whole sequences and can only be shown by the bench's scenarios:
- the exact interleaved order from several start offsets;
- the return to the start offset after the last beat;
- the order being held when order_ilv changes mid-burst;
- back-to-back reloads.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } beat_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clear,
   output logic [BEAT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (en) begin
         if (clear) cnt <= '0;
         else       cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/burst_addr_hold.sv
module burst_addr_hold
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2,
   localparam int UP_W  = ADDR_W - BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              ilv_in,
   output logic [UP_W-1:0]   upper,
   output logic [BEAT_W-1:0] start,
   output beat_order_e       order
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper <= '0;
         start <= '0;
         order <= ORD_LINEAR;
      end else if (load) begin
         upper <= addr_in[ADDR_W-1:BEAT_W];
         start <= addr_in[BEAT_W-1:0];
         order <= ilv_in ? ORD_XOR : ORD_LINEAR;
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] cnt,
   input  beat_order_e       order,
   output logic [BEAT_W-1:0] beat
);
   logic [BEAT_W-1:0] lin_beat;
   logic [BEAT_W-1:0] xor_beat;

   assign lin_beat = start + cnt;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
      assign xor_beat[b] = start[b] ^ cnt[b];
   end

   assign beat = (order == ORD_XOR) ? xor_beat : lin_beat;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              advance,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int UP_W = ADDR_W - BEAT_W;

   if (BEAT_W < 1) begin : g_chk_beat
      $error("burst_seq: BEAT_W must be at least 1");
   end
   if (ADDR_W <= BEAT_W) begin : g_chk_addr
      $error("burst_seq: ADDR_W must exceed BEAT_W");
   end

   logic              en;
   logic              load;
   logic [BEAT_W-1:0] cnt;
   logic [BEAT_W-1:0] start;
   logic [BEAT_W-1:0] beat;
   logic [UP_W-1:0]   upper;
   beat_order_e       order;

   assign en   = !ce_n;
   assign load = en && !advance;

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .clear (!advance),
      .cnt   (cnt)
   );

   burst_addr_hold #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .addr_in (addr_in),
      .ilv_in  (order_ilv),
      .upper   (upper),
      .start   (start),
      .order   (order)
   );

   burst_order_map #(.BEAT_W(BEAT_W)) u_map (
      .start (start),
      .cnt   (cnt),
      .order (order),
      .beat  (beat)
   );

   assign addr_out = {upper, beat};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              advance,
   input logic              order_ilv,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out
);
   logic ilv_seen;
   logic rst_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ilv_seen <= 1'b0;
      end else if (!ce_n && !advance) begin
         ilv_seen <= order_ilv;
      end
   end

   always_ff @(posedge clk) begin
      rst_seen <= rst_seen | !rst_n;
      if (rst_seen && $past(!rst_n)) begin
         assert_reset_zero_R1: assert (addr_out == '0)
            else $error("R1: address not zero after reset");
      end
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !advance) |=> addr_out == $past(addr_in));

   assert_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && advance) |=>
         addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

   assert_beat_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && advance) |=>
         addr_out[BEAT_W-1:0] != $past(addr_out[BEAT_W-1:0]));

   assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && advance && !ilv_seen) |=>
         addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 1'b1);

   assert_ilv_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && advance && ilv_seen) |=>
         addr_out[0] != $past(addr_out[0]));

   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> $stable(addr_out));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .advance   (advance),
   .order_ilv (order_ilv),
   .addr_in   (addr_in),
   .addr_out  (addr_out)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          advance = 1'b0;
   logic          order_ilv = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [AW-1:0] exp;
      string         req;
   } item_t;
   item_t sb[$];

   // Reference model of the requirements
   logic [AW-BW-1:0] m_upper = '0;
   logic [BW-1:0]    m_start = '0;
   logic [BW-1:0]    m_k = '0;
   logic             m_ilv = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_seq #(.ADDR_W(AW), .BEAT_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .advance(advance),
      .order_ilv(order_ilv), .addr_in(addr_in), .addr_out(addr_out)
   );

   function automatic logic [AW-1:0] model_addr();
      logic [BW-1:0] low;
      low = m_ilv ? (m_start ^ m_k) : (m_start + m_k);
      return {m_upper, low};
   endfunction

   task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic c_n, input logic adv, input logic ilv,
                        input logic [AW-1:0] a, input string req);
      item_t it;
      @(negedge clk);
      ce_n = c_n; advance = adv; order_ilv = ilv; addr_in = a;
      if (!c_n) begin
         if (!adv) begin
            m_upper = a[AW-1:BW]; m_start = a[BW-1:0]; m_k = '0; m_ilv = ilv;
         end else begin
            m_k = m_k + 1'b1;
         end
      end
      it.exp = model_addr();
      it.req = req;
      sb.push_back(it);
   endtask

   // Monitor: compare one item after each edge it belongs to
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(addr_out, it.exp, it.req);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check(addr_out, '0, "R1 in reset");
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1 check(addr_out, '0, "R1 after release");

      // R2, R3, R4, R6: linear from start 1, full wrap
      drive(0, 0, 0, 20'hABCD1, "R2 load");
      drive(0, 1, 0, '0, "R4 beat1 R3");
      drive(0, 1, 0, '0, "R4 beat2");
      drive(0, 1, 0, '0, "R4 beat3");
      drive(0, 1, 0, '0, "R6 wrap linear");

      // R5, R6: interleaved from start 1
      drive(0, 0, 1, 20'h12341, "R2 load ilv");
      drive(0, 1, 0, '0, "R5 beat1");
      drive(0, 1, 0, '0, "R5 beat2");
      drive(0, 1, 0, '0, "R5 beat3");
      drive(0, 1, 0, '0, "R6 wrap ilv");

      // R5: interleaved from start 2
      drive(0, 0, 1, 20'h5A5A6, "R2 load ilv2");
      drive(0, 1, 1, '0, "R5 s2 beat1");
      drive(0, 1, 1, '0, "R5 s2 beat2");
      drive(0, 1, 1, '0, "R5 s2 beat3");

      // R7: frozen with varied inputs
      drive(1, 1, 0, 20'hFFFFF, "R7 hold adv");
      drive(1, 0, 1, 20'h00003, "R7 hold load");
      drive(0, 1, 1, '0, "R7 resume");

      // R8: order change mid-burst ignored
      drive(0, 0, 0, 20'h0F0F1, "R2 load lin");
      drive(0, 1, 1, '0, "R8 mode ignored beat1");
      drive(0, 1, 1, '0, "R8 mode ignored beat2");

      // R9: back-to-back loads and reload mid-burst
      drive(0, 0, 1, 20'h22223, "R9 load a");
      drive(0, 0, 0, 20'h33332, "R9 load b");
      drive(0, 1, 0, '0, "R9 step b");
      drive(0, 0, 1, 20'h44440, "R9 reload");
      drive(0, 1, 0, '0, "R9 step ilv");
      drive(0, 1, 0, '0, "R9 step ilv2");

      @(negedge clk); ce_n = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule